// File: doc/BRIEF.md
# Crosspoint Routing Configuration Controller

This block stores the routing plan for a switch matrix with sixteen outputs and sixteen inputs. For every matrix output it presents a 4-bit source number and an enable bit. The storage has two ranks. The holding rank is what gets written. It can be filled by a serial shift stream of 80 bits, or it can be changed one output at a time through a parallel write port. The active rank is what drives the matrix. It copies the holding rank whenever the active-low update control and the active-low chip enable are both low.

The last bit of the serial shift chain is brought out on a serial data output. Several controllers can therefore be chained, with the stream for the far device sent first. An asynchronous active-low reset turns every active enable off. It leaves the holding rank and the active source numbers untouched, so a later update reapplies the stored plan. The holding rank changes on the falling edge of `clk`. The active rank changes on the rising edge, so a write followed by an update completes in a single clock period.

Top module: `xp_cfg_ctrl`

## Requirements
- R1: While `rst_n` is low, every `en_o` bit reads 0 at once. Reset does not alter the holding rank, so an update issued after reset, with no new load, brings back the previous routing.
- R2: With `ce_n`=0 and `ser_par_n`=0, each falling edge of `clk` shifts `sdi` into the holding rank by one position.
- R3: A serial image is 80 bits long, in 16 groups of 5 bits. The group for output 15 is sent first and the group for output 0 is sent last. Within a group the bits are sent in this order: select bit 0, select bit 1, select bit 2, select bit 3, then the enable bit.
- R4: On a rising edge of `clk` with `upd_n`=0 and `ce_n`=0, the active rank takes the holding rank. In every other case the outputs hold their value. After reset the outputs stay disabled until the first such update.
- R5: If `upd_n` is kept low while bits are shifting, each intermediate state of the holding rank reaches the outputs. After five shifts, output 0 shows the five bits just sent.
- R6: For an output whose enable is 0, its 4-bit field of `sel_o` (bits 4*o+3 down to 4*o) reads 0, whatever select bits are stored.
- R7: With `ser_par_n`=1 and `ce_n`=0, a falling edge with `par_wr`=1 replaces the entry of output `par_addr` with `par_sel` and `par_en`. All other entries stay unchanged. With `par_wr`=0 nothing changes.
- R8: While `ce_n`=1, no shift, no parallel write and no update takes place. `sdo` stays steady.
- R9: `sdo` shows the bit at the far end of the holding rank. Right after an 80-bit load it equals the first bit sent. Two chained controllers (`sdo` to `sdi`) that receive a 160-bit stream, far device first, both take the correct routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock. The holding rank uses the falling edge and the active rank uses the rising edge. |
| rst_n | input | 1 | Asynchronous active-low reset. Clears the active enables only. |
| ce_n | input | 1 | Active-low chip enable. Gates loading and update. |
| ser_par_n | input | 1 | Load mode: 0 selects serial shifting, 1 selects parallel write. |
| upd_n | input | 1 | Active-low update. Copies the holding rank into the active rank. |
| sdi | input | 1 | Serial data input. |
| sdo | output | 1 | Serial data output, for chaining. |
| par_addr | input | 4 | Output number addressed by a parallel write. |
| par_sel | input | 4 | Source number for a parallel write. |
| par_en | input | 1 | Enable bit for a parallel write. |
| par_wr | input | 1 | Parallel write strobe. |
| sel_o | output | 64 | Source number per output, 4 bits each, output o at bits 4*o+3 down to 4*o. |
| en_o | output | 16 | Enable per output. |

## Verification
A parallel write and an update can fall in the same clock period. The write lands on the falling edge and the copy happens on the following rising edge. The bench runs every parallel write of a full sweep over all 16 addresses and 16 source values with `upd_n` already low. It then expects the new entry, and every untouched entry, on the outputs one rising edge later. Shifting and update also coincide: `upd_n` is held low during a five-bit shift, and output 0 is judged against the bits just sent.

// File: rtl/xp_cfg_pkg.sv
package xp_cfg_pkg;

    // Load-mode encoding of ser_par_n.
    typedef enum logic {
        LOAD_SERIAL   = 1'b0,
        LOAD_PARALLEL = 1'b1
    } load_mode_e;

    // Lowest chain position of output o's group. The first group shifted
    // (highest output) ends at the far end of the chain.
    function automatic int unsigned grp_base(input int unsigned n_out,
                                             input int unsigned grp_w,
                                             input int unsigned o);
        return grp_w * (n_out - 1 - o);
    endfunction

endpackage

// File: rtl/xp_hold_rank.sv
module xp_hold_rank
    import xp_cfg_pkg::*;
#(
    parameter int unsigned N_OUT = 16,
    parameter int unsigned SEL_W = 4,
    localparam int unsigned GRP_W   = SEL_W + 1,
    localparam int unsigned CHAIN_W = N_OUT * GRP_W,
    localparam int unsigned ADDR_W  = $clog2(N_OUT)
) (
    input  logic               clk,
    input  logic               ce_n,
    input  logic               ser_par_n,
    input  logic               sdi,
    input  logic               par_wr,
    input  logic [ADDR_W-1:0]  par_addr,
    input  logic [SEL_W-1:0]   par_sel,
    input  logic               par_en,
    output logic [CHAIN_W-1:0] hold_q,
    output logic               sdo
);

    logic [CHAIN_W-1:0] hold_d;

    always_comb begin
        hold_d = hold_q;
        if (!ce_n) begin
            if (load_mode_e'(ser_par_n) == LOAD_SERIAL) begin
                // New bit enters at the top; the oldest bit leaves at bit 0.
                hold_d = {sdi, hold_q[CHAIN_W-1:1]};
            end else if (par_wr) begin
                for (int o = 0; o < N_OUT; o++) begin
                    if (par_addr == ADDR_W'(o)) begin
                        hold_d[grp_base(N_OUT, GRP_W, o) +: GRP_W] = {par_en, par_sel};
                    end
                end
            end
        end
    end

    // The holding rank has no reset: its power-up content is undefined.
    always_ff @(negedge clk) begin
        hold_q <= hold_d;
    end

    assign sdo = hold_q[0];

endmodule

// File: rtl/xp_active_rank.sv
module xp_active_rank
    import xp_cfg_pkg::*;
#(
    parameter int unsigned N_OUT = 16,
    parameter int unsigned SEL_W = 4,
    localparam int unsigned GRP_W   = SEL_W + 1,
    localparam int unsigned CHAIN_W = N_OUT * GRP_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ce_n,
    input  logic                     upd_n,
    input  logic [CHAIN_W-1:0]       hold_i,
    output logic [N_OUT*SEL_W-1:0]   act_sel,
    output logic [N_OUT-1:0]         act_en
);

    typedef struct packed {
        logic [N_OUT-1:0]       en;
        logic [N_OUT*SEL_W-1:0] sel;
    } act_t;

    act_t act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (!upd_n && !ce_n) begin
            for (int o = 0; o < N_OUT; o++) begin
                act_d.sel[o*SEL_W +: SEL_W] = hold_i[grp_base(N_OUT, GRP_W, o) +: SEL_W];
                act_d.en[o]                 = hold_i[grp_base(N_OUT, GRP_W, o) + SEL_W];
            end
        end
    end

    // Reset clears only the enables; the stored selects survive.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q.en <= '0;
        end else begin
            act_q <= act_d;
        end
    end

    assign act_sel = act_q.sel;
    assign act_en  = act_q.en;

endmodule

// File: rtl/xp_cfg_ctrl.sv
module xp_cfg_ctrl
    import xp_cfg_pkg::*;
#(
    parameter int unsigned N_OUT = 16,
    parameter int unsigned SEL_W = 4,
    localparam int unsigned GRP_W   = SEL_W + 1,
    localparam int unsigned CHAIN_W = N_OUT * GRP_W,
    localparam int unsigned ADDR_W  = $clog2(N_OUT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ce_n,
    input  logic                   ser_par_n,
    input  logic                   upd_n,
    input  logic                   sdi,
    output logic                   sdo,
    input  logic [ADDR_W-1:0]      par_addr,
    input  logic [SEL_W-1:0]       par_sel,
    input  logic                   par_en,
    input  logic                   par_wr,
    output logic [N_OUT*SEL_W-1:0] sel_o,
    output logic [N_OUT-1:0]       en_o
);

    logic [CHAIN_W-1:0]     hold_q;
    logic [N_OUT*SEL_W-1:0] act_sel;
    logic [N_OUT-1:0]       act_en;

    xp_hold_rank #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_hold (
        .clk       (clk),
        .ce_n      (ce_n),
        .ser_par_n (ser_par_n),
        .sdi       (sdi),
        .par_wr    (par_wr),
        .par_addr  (par_addr),
        .par_sel   (par_sel),
        .par_en    (par_en),
        .hold_q    (hold_q),
        .sdo       (sdo)
    );

    xp_active_rank #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_act (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .upd_n   (upd_n),
        .hold_i  (hold_q),
        .act_sel (act_sel),
        .act_en  (act_en)
    );

    // A disabled output routes nothing: its select field reads zero.
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        assign sel_o[o*SEL_W +: SEL_W] = act_en[o] ? act_sel[o*SEL_W +: SEL_W] : '0;
    end

    assign en_o = act_en;

endmodule

// File: rtl/xp_cfg_ctrl_chk.sv
module xp_cfg_ctrl_chk #(
    parameter int unsigned N_OUT = 16,
    parameter int unsigned SEL_W = 4,
    localparam int unsigned GRP_W   = SEL_W + 1,
    localparam int unsigned CHAIN_W = N_OUT * GRP_W
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ce_n,
    input logic                   ser_par_n,
    input logic                   upd_n,
    input logic                   sdo,
    input logic [CHAIN_W-1:0]     hold_q,
    input logic [N_OUT*SEL_W-1:0] sel_o,
    input logic [N_OUT-1:0]       en_o
);

    logic [N_OUT-1:0] hold_en;
    for (genvar o = 0; o < N_OUT; o++) begin : g_en
        assign hold_en[o] = hold_q[GRP_W*(N_OUT-1-o) + SEL_W];
    end

    p_reset_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> en_o == '0);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_n || ce_n) |=> ($stable(en_o) && $stable(sel_o)));

    p_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_n && !ce_n) |=> en_o == $past(hold_en));

    p_shift_r2: assert property (@(negedge clk) disable iff (!rst_n)
        (!ce_n && !ser_par_n) |=> sdo == $past(hold_q[1]));

    p_ce_freeze_r8: assert property (@(negedge clk) disable iff (!rst_n)
        ce_n |=> $stable(hold_q));

endmodule

bind xp_cfg_ctrl xp_cfg_ctrl_chk #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .ser_par_n (ser_par_n),
    .upd_n     (upd_n),
    .sdo       (sdo),
    .hold_q    (hold_q),
    .sel_o     (sel_o),
    .en_o      (en_o)
);

// File: tb/xp_cfg_ctrl_bench.sv
module xp_cfg_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        ce_n = 1'b1;
    logic        ser_par_n = 1'b1;
    logic        upd_n = 1'b1;
    logic        sdi = 1'b0;
    logic [3:0]  par_addr = '0;
    logic [3:0]  par_sel = '0;
    logic        par_en = 1'b0;
    logic        par_wr = 1'b0;
    logic        sdo, b_sdo;
    logic [63:0] sel_o, b_sel;
    logic [15:0] en_o, b_en;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int m_sel [16];
    bit m_en  [16];
    int b_msel [16];
    bit b_men  [16];

    always #2 clk = ~clk;

    xp_cfg_ctrl u_xp_cfg_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ser_par_n(ser_par_n), .upd_n(upd_n),
        .sdi(sdi), .sdo(sdo), .par_addr(par_addr), .par_sel(par_sel), .par_en(par_en),
        .par_wr(par_wr), .sel_o(sel_o), .en_o(en_o)
    );

    // Second device of a two-long chain, fed from the first one's sdo.
    xp_cfg_ctrl u_chain_b (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ser_par_n(ser_par_n), .upd_n(upd_n),
        .sdi(sdo), .sdo(b_sdo), .par_addr(par_addr), .par_sel(par_sel), .par_en(par_en),
        .par_wr(par_wr), .sel_o(b_sel), .en_o(b_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare every output of device A (or B) with its model.
    task automatic check_all(input string req, input bit dev_b);
        for (int o = 0; o < 16; o++) begin
            int ae, as, ee, es;
            ae = dev_b ? int'(b_en[o]) : int'(en_o[o]);
            as = dev_b ? int'(b_sel[o*4 +: 4]) : int'(sel_o[o*4 +: 4]);
            ee = dev_b ? int'(b_men[o]) : int'(m_en[o]);
            es = ee != 0 ? (dev_b ? b_msel[o] : m_sel[o]) : 0;
            chk($sformatf("%s out%0d en", req, o), ae, ee);
            chk($sformatf("%s out%0d sel", req, o), as, es);
        end
    endtask

    function automatic logic [79:0] image(input bit dev_b);
        logic [79:0] img;
        for (int o = 0; o < 16; o++) begin
            int g;
            g = 15 - o;
            img[5*g +: 4] = 4'(dev_b ? b_msel[o] : m_sel[o]);
            img[5*g + 4]  = dev_b ? b_men[o] : m_en[o];
        end
        return img;
    endfunction

    task automatic shift_bit(input logic b, input logic ce);
        @(posedge clk); #1;
        ce_n = ce; ser_par_n = 1'b0; par_wr = 1'b0; sdi = b;
    endtask

    task automatic end_shift();
        @(posedge clk); #1;
        ce_n = 1'b1; ser_par_n = 1'b1;
    endtask

    task automatic load(input logic [79:0] img, input logic ce);
        for (int k = 0; k < 80; k++) shift_bit(img[k], ce);
        end_shift();
    endtask

    task automatic update(input logic ce);
        @(posedge clk); #1;
        ce_n = ce; ser_par_n = 1'b1; par_wr = 1'b0; upd_n = 1'b0;
        @(posedge clk); #1;
        upd_n = 1'b1; ce_n = 1'b1;
    endtask

    // Parallel write with update in the same clock period.
    task automatic par_write(input int a, input int s, input bit e, input logic wr, input logic ce);
        @(posedge clk); #1;
        ce_n = ce; ser_par_n = 1'b1; par_wr = wr; upd_n = 1'b0;
        par_addr = 4'(a); par_sel = 4'(s); par_en = e;
        @(posedge clk); #1;
        par_wr = 1'b0; upd_n = 1'b1; ce_n = 1'b1;
    endtask

    initial begin
        logic [79:0] img;
        logic        sdo_before;
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 / R6: reset state
        chk("R1 reset en A", int'(en_o), 0);
        chk("R1 reset en B", int'(b_en), 0);
        chk("R6 reset sel A", int'(sel_o != 0), 0);

        // R4: loaded but not updated -> still disabled
        for (int o = 0; o < 16; o++) begin
            m_sel[o] = (o * 7 + 3) % 16;
            m_en[o]  = (o % 3) != 0;
        end
        img = image(0);
        load(img, 1'b0);
        #1;
        chk("R4 no update yet", int'(en_o), 0);
        chk("R9 sdo first bit", int'(sdo), int'(img[0]));
        update(1'b0);
        #1 check_all("R3 R4 R6 serial", 0);

        // R2 / R3: several serial patterns
        for (int k = 1; k <= 3; k++) begin
            for (int o = 0; o < 16; o++) begin
                m_sel[o] = (o * 5 + k * 3) % 16;
                m_en[o]  = ((o + k) % 4) != 0;
            end
            load(image(0), 1'b0);
            update(1'b0);
            #1 check_all("R2 R3 pattern", 0);
        end

        // R7: parallel sweep, write and update in the same period
        for (int k = 0; k < 16; k++) begin
            for (int a = 0; a < 16; a++) begin
                m_sel[a] = (a + k) % 16;
                m_en[a]  = ((a + k) % 4) != 0;
                par_write(a, m_sel[a], m_en[a], 1'b1, 1'b0);
                #1 check_all("R7 parallel", 0);
            end
        end

        // R7: strobe low changes nothing
        par_write(5, (m_sel[5] + 1) % 16, ~m_en[5], 1'b0, 1'b0);
        #1 check_all("R7 no strobe", 0);

        // R8: chip enable high blocks shift, write and update
        sdo_before = sdo;
        load({80{1'b1}}, 1'b1);
        #1 chk("R8 sdo steady", int'(sdo), int'(sdo_before));
        par_write(3, (m_sel[3] + 2) % 16, ~m_en[3], 1'b1, 1'b1);
        update(1'b0);
        #1 check_all("R8 ce high", 0);
        for (int o = 0; o < 16; o++) begin
            b_msel[o] = m_sel[o]; b_men[o] = m_en[o];   // save plan
            m_sel[o] = (o * 3 + 1) % 16;
            m_en[o]  = (o % 2) == 0;
        end
        load(image(0), 1'b0);
        update(1'b1);
        for (int o = 0; o < 16; o++) begin
            m_sel[o] = b_msel[o]; m_en[o] = b_men[o];
        end
        #1 check_all("R8 update blocked", 0);
        for (int o = 0; o < 16; o++) begin
            m_sel[o] = (o * 3 + 1) % 16;
            m_en[o]  = (o % 2) == 0;
        end
        update(1'b0);
        #1 check_all("R4 update applies", 0);

        // R1: reset clears enables only; update restores routing
        @(posedge clk); #1 rst_n = 1'b0;
        #1 chk("R1 reset mid en", int'(en_o), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        update(1'b0);
        #1 check_all("R1 restored", 0);

        // R5: transparent update while shifting
        upd_n = 1'b0;
        shift_bit(1'b1, 1'b0);  // sel bit0
        shift_bit(1'b0, 1'b0);
        shift_bit(1'b0, 1'b0);
        shift_bit(1'b1, 1'b0);  // sel bit3 -> 9
        shift_bit(1'b1, 1'b0);  // enable
        end_shift();
        #1;
        chk("R5 out0 en", int'(en_o[0]), 1);
        chk("R5 out0 sel", int'(sel_o[3:0]), 9);
        upd_n = 1'b1;

        // R9: two-device chain, far device data first
        for (int o = 0; o < 16; o++) begin
            m_sel[o]  = (o * 11 + 2) % 16;
            m_en[o]   = (o % 5) != 1;
            b_msel[o] = (o * 13 + 7) % 16;
            b_men[o]  = (o % 3) != 2;
        end
        img = image(1);
        for (int k = 0; k < 80; k++) shift_bit(img[k], 1'b0);
        img = image(0);
        for (int k = 0; k < 80; k++) shift_bit(img[k], 1'b0);
        end_shift();
        update(1'b0);
        #1;
        check_all("R9 chain A", 0);
        check_all("R9 chain B", 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule